// File: doc/BRIEF.md
# Serial Port Pin Multiplexer

This block shares eight device pins between two UART channels, one SPI port and a general-purpose I/O port. Each pin carries either its serial signal or one GPIO bit. The UART and SPI controllers choose the function of their own pins through their enable bits. The three SPI data and select pins instead follow an assignment register that software writes.

The pin direction always comes from a direction register, including when the pin is in serial mode. An output pin in serial mode drives the peripheral's signal to the pad. An output pin in GPIO mode drives the latched GPIO data bit. On a GPIO read, input pins return the synchronised pad level and output pins return their latched value.

A CPU writes the three registers over a simple single-cycle port and reads them back combinationally. The pins use a fixed bit order, highest first:

| Bit | Pin |
|---|---|
| 7 | UART A transmit |
| 6 | UART A receive |
| 5 | UART B transmit |
| 4 | UART B receive |
| 3 | SPI select |
| 2 | SPI clock |
| 1 | SPI master-out |
| 0 | SPI master-in |

Top module: `serial_pin_mux`

## Requirements
- R1: After reset, all registers read 0, `pad_oe` is 0 and `pad_o` is 0, so every pin is a GPIO input.
- R2: Register address 0 is the direction register. One clock after a write, `pad_oe` equals the written value, whatever function each pin has.
- R3: Register address 1 is the assignment register. Only bit 3 (select), bit 1 (master-out) and bit 0 (master-in) are stored, and a 1 selects SPI mode. The other bits always read 0.
- R4: Bit 2 (SPI clock) is in serial mode exactly when `spi_en` is 1.
- R5: Bits 7 and 5 are in serial mode exactly when the transmit enable of UART A and UART B, respectively, is 1. Bits 6 and 4 follow the receive enables of UART A and UART B in the same way.
- R6: For each bit, `pad_o` equals `per_out` when the bit is in serial mode, and the latched GPIO data bit when it is in GPIO mode.
- R7: `per_in` passes `pad_i` for bits in serial mode and is 0 for bits in GPIO mode.
- R8: Register address 2 is the GPIO data register. A read returns the latched bit for output pins and `pad_i` delayed by SYNC_STAGES clocks (default 2) for input pins.
- R9: A write to address 3 changes no register, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| uart_a_tx_en | input | 1 | UART A transmitter enable |
| uart_a_rx_en | input | 1 | UART A receiver enable |
| uart_b_tx_en | input | 1 | UART B transmitter enable |
| uart_b_rx_en | input | 1 | UART B receiver enable |
| spi_en | input | 1 | SPI enable |
| per_out | input | 8 | Peripheral signals toward the pads |
| per_in | output | 8 | Pad levels toward the peripherals |
| pad_o | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_i | input | 8 | Pad input level |

## Verification
Results arrive at three different times.

- **One clock after a write:** register writes update the stored state, so `pad_oe` and `pad_o` reflect a write one clock later. The bench drives every write at a falling edge and samples at the next falling edge.
- **Same cycle:** mode enables, `per_out` and `pad_i` reach `pad_o` and `per_in` through logic only. Register reads are also combinational. The bench samples these a short delay after driving them, within the same half period.
- **SYNC_STAGES clocks later:** a pad change on an input pin appears in a GPIO read after that many rising edges. The bench reads once before the last stage has loaded and expects the old value, then reads again after it has loaded and expects the new one.

// File: rtl/spm_pkg.sv
package spm_pkg;
   localparam int PINS = 8;
   // bit positions of the shared pins
   localparam int B_UA_TX = 7;
   localparam int B_UA_RX = 6;
   localparam int B_UB_TX = 5;
   localparam int B_UB_RX = 4;
   localparam int B_SEL   = 3;
   localparam int B_CLK   = 2;
   localparam int B_MO    = 1;
   localparam int B_MI    = 0;
   localparam logic [PINS-1:0] ASG_MASK =
      PINS'((1 << B_SEL) | (1 << B_MO) | (1 << B_MI));
   typedef enum logic [1:0] {
      REG_DIR  = 2'd0,
      REG_ASG  = 2'd1,
      REG_DAT  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/spm_in_sync.sv
module spm_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 0 || STAGES > 4) $error("spm_in_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spm_func_sel.sv
module spm_func_sel
   import spm_pkg::*;
(
   input  logic            ua_tx_en,
   input  logic            ua_rx_en,
   input  logic            ub_tx_en,
   input  logic            ub_rx_en,
   input  logic            spi_en,
   input  logic [PINS-1:0] asg_q,
   output logic [PINS-1:0] serial_sel
);
   always_comb begin
      serial_sel          = '0;
      serial_sel[B_UA_TX] = ua_tx_en;
      serial_sel[B_UA_RX] = ua_rx_en;
      serial_sel[B_UB_TX] = ub_tx_en;
      serial_sel[B_UB_RX] = ub_rx_en;
      serial_sel[B_CLK]   = spi_en;
      serial_sel[B_SEL]   = asg_q[B_SEL];
      serial_sel[B_MO]    = asg_q[B_MO];
      serial_sel[B_MI]    = asg_q[B_MI];
   end
endmodule

// File: rtl/spm_regs.sv
module spm_regs
   import spm_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PINS-1:0]   wdata,
   input  logic [PINS-1:0]   pad_sync,
   output logic [PINS-1:0]   dir_q,
   output logic [PINS-1:0]   asg_q,
   output logic [PINS-1:0]   dat_q,
   output logic [PINS-1:0]   rdata
);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(REG_DIR);
   localparam logic [ADDR_W-1:0] A_ASG = ADDR_W'(REG_ASG);
   localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(REG_DAT);
   localparam logic [ADDR_W-1:0] A_NON = ADDR_W'(REG_NONE);

   initial begin
      if (ADDR_W < 2) $error("spm_regs: ADDR_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         asg_q <= '0;
         dat_q <= '0;
      end else if (we) begin
         unique case (addr)
            A_DIR:   dir_q <= wdata;
            A_ASG:   asg_q <= wdata & ASG_MASK;
            A_DAT:   dat_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (addr)
         A_DIR:   rdata = dir_q;
         A_ASG:   rdata = asg_q;
         A_DAT:   rdata = (dir_q & dat_q) | (~dir_q & pad_sync);
         default: rdata = '0;
      endcase
   end

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_DIR) |=> dir_q == $past(wdata));
   p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_NON) |=> ($stable(dir_q) && $stable(asg_q) && $stable(dat_q)));
   p_dat_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_DAT) |-> ((rdata & dir_q) == (dat_q & dir_q)));
endmodule

// File: rtl/serial_pin_mux.sv
module serial_pin_mux
   import spm_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              uart_a_tx_en,
   input  logic              uart_a_rx_en,
   input  logic              uart_b_tx_en,
   input  logic              uart_b_rx_en,
   input  logic              spi_en,
   input  logic [7:0]        per_out,
   output logic [7:0]        per_in,
   output logic [7:0]        pad_o,
   output logic [7:0]        pad_oe,
   input  logic [7:0]        pad_i
);
   logic [PINS-1:0] dir_q, asg_q, dat_q, pad_sync, serial_sel;

   spm_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_i), .q(pad_sync)
   );

   spm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .pad_sync(pad_sync),
      .dir_q(dir_q), .asg_q(asg_q), .dat_q(dat_q), .rdata(reg_rdata)
   );

   spm_func_sel u_sel (
      .ua_tx_en(uart_a_tx_en), .ua_rx_en(uart_a_rx_en),
      .ub_tx_en(uart_b_tx_en), .ub_rx_en(uart_b_rx_en),
      .spi_en(spi_en), .asg_q(asg_q), .serial_sel(serial_sel)
   );

   generate
      for (genvar i = 0; i < PINS; i++) begin : g_pin
         assign pad_o[i]  = serial_sel[i] ? per_out[i] : dat_q[i];
         assign per_in[i] = serial_sel[i] & pad_i[i];
      end
   endgenerate
   assign pad_oe = dir_q;

   p_dir_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(REG_DIR)) |=> pad_oe == $past(reg_wdata));
   p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(REG_ASG)) |-> ((reg_rdata & ~ASG_MASK) == '0));
   p_clk_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en |-> pad_o[B_CLK] == per_out[B_CLK]);
   p_tx_gpio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !uart_a_tx_en |-> pad_o[B_UA_TX] == dat_q[B_UA_TX]);
   p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !uart_a_rx_en |-> per_in[B_UA_RX] == 1'b0);
endmodule

// File: tb/sim_serial_pin_mux.sv
`timescale 1ns/1ps
module sim_serial_pin_mux;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ua_tx = 0, ua_rx = 0, ub_tx = 0, ub_rx = 0, spi = 0;
   logic [7:0] per_out = '0, pad_i = '0;
   logic [7:0] per_in, pad_o, pad_oe;
   int nchk = 0, nfail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   serial_pin_mux u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .uart_a_tx_en(ua_tx), .uart_a_rx_en(ua_rx),
      .uart_b_tx_en(ub_tx), .uart_b_rx_en(ub_rx), .spi_en(spi),
      .per_out(per_out), .per_in(per_in), .pad_o(pad_o),
      .pad_oe(pad_oe), .pad_i(pad_i)
   );

   // {ctl[4:0]=uaTX,uaRX,ubTX,ubRX,spi, dir, asg, gpio, per_out, pad_i, exp pad_o, exp per_in}
   localparam logic [60:0] VEC [4] = '{
      {5'b00000, 8'hFF, 8'h00, 8'hA5, 8'hFF, 8'hFF, 8'hA5, 8'h00},
      {5'b11111, 8'hF0, 8'h0B, 8'h00, 8'hC3, 8'h5A, 8'hC3, 8'h5A},
      {5'b10100, 8'h0F, 8'h08, 8'hFF, 8'h00, 8'hFF, 8'h57, 8'hA8},
      {5'b01011, 8'h33, 8'hF2, 8'h3C, 8'hFF, 8'h0F, 8'h7E, 8'h06}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pad_o", pad_o, 8'h00);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), r);
         chk("R1 rdata", r, 8'h00);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R2 R4 R5 R6 R7 (and R3 readback)
      for (int k = 0; k < 4; k++) begin
         logic [60:0] v;
         v = VEC[k];
         {ua_tx, ua_rx, ub_tx, ub_rx, spi} = v[60:56];
         per_out = v[31:24];
         pad_i   = v[23:16];
         wr(2'd0, v[55:48]);
         wr(2'd1, v[47:40]);
         wr(2'd2, v[39:32]);
         #0.5;
         chk("R2 pad_oe", pad_oe, v[55:48]);
         chk("R4 R5 R6 pad_o", pad_o, v[15:8]);
         chk("R7 per_in", per_in, v[7:0]);
         rd(2'd1, r);
         chk("R3 asg readback", r, v[47:40] & 8'h0B);
      end

      // R4 SCK follows spi enable alone with assignment bits cleared
      {ua_tx, ua_rx, ub_tx, ub_rx, spi} = 5'b00001;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      per_out = 8'hFF;
      #0.5;
      chk("R4 sck serial", pad_o, 8'h04);
      spi = 1'b0;
      #0.5;
      chk("R4 sck gpio", pad_o, 8'h00);

      // R8 GPIO read with input sync latency
      pad_i = 8'h3C;
      wr(2'd0, 8'h0F);
      wr(2'd2, 8'hA5);
      repeat (2) @(negedge clk);
      rd(2'd2, r);
      chk("R8 read mix", r, 8'h35);
      pad_i = 8'hC3;
      @(negedge clk);
      rd(2'd2, r);
      chk("R8 before sync", r, 8'h35);
      @(negedge clk);
      rd(2'd2, r);
      chk("R8 after sync", r, 8'hC5);

      // R9 unmapped address
      wr(2'd1, 8'h0B);
      wr(2'd3, 8'hFF);
      rd(2'd0, r); chk("R9 dir kept", r, 8'h0F);
      rd(2'd1, r); chk("R9 asg kept", r, 8'h0B);
      rd(2'd2, r); chk("R9 dat kept", r, 8'hC5);
      rd(2'd3, r); chk("R9 read zero", r, 8'h00);
      chk("R9 pad_oe kept", pad_oe, 8'h0F);

      finish_run();
   end
endmodule